// File: doc/BRIEF.md
# Programmable Reload Down-Counter Timer

The block is a 16-bit down-counting timer driven through a small byte-wide register port. Software writes a 16-bit start value as two bytes, then writes the control register to pick a prescaler ratio and a mode, and to request that the start value be copied into the counter. Each prescaled tick lowers the count by one. When a tick arrives while the count is 1, the block raises a one-cycle `timeout` pulse and sets a sticky end-of-count flag. In repeat mode the start value is reloaded on that tick and counting goes on. In single-shot mode the counter parks at zero.

A debug-halt input can freeze the timer, so that software stopped at a breakpoint sees a stable count. This only happens when the freeze-enable control bit is set. Otherwise the timer keeps running through the halt. The live count is read low byte first. That read captures the high byte, so a later high-byte read completes a coherent 16-bit snapshot.

Top module: `reload_timer_top`

## Requirements
- R1: After reset, the control register, both start-value bytes, both count bytes and `timeout` all read 0.
- R2: While the run bit (control bit 0) is 0, the count holds its value and `timeout` stays low.
- R3: Writing control with bit 1 set copies the start value {addr 2, addr 1} into the counter at the next clock edge. Bit 1 reads back as 0 once that load has happened.
- R4: The 2-bit divider field (control bits 3:2) gives one count step every 4, 16, 64 or 256 clock cycles for codes 0, 1, 2 and 3.
- R5: With the repeat bit (control bit 4) clear, the counter stops at 0 after a single timeout and makes no further pulses until it is loaded again.
- R6: With the repeat bit set, the tick that ends a count reloads the start value, and the timeout repeats every start-value × divider cycles.
- R7: The timeout pulse lasts exactly one cycle and appears on the tick that takes the count from 1 to its next value. That pulse sets the end-of-count flag (control bit 7).
- R8: The end-of-count flag stays set until the control register is read. That read returns 1 in bit 7, and a following read returns 0.
- R9: When `dbg_halt` is high and the freeze bit (control bit 5) is set, the count does not change. When the freeze bit is clear, `dbg_halt` has no effect.
- R10: A start value of 0000h gives 65536 steps: the first tick takes the count to FFFFh with no timeout.
- R11: Reading the count low byte (addr 3) captures the high byte. A later read of addr 4 returns that captured byte, even if the count has moved since.
- R12: A load or a 0-to-1 change of the run bit restarts the prescaler. The first step therefore comes exactly one full divider period after the restart edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects on flag and snapshot) |
| addr | input | 3 | Register select: 0 control, 1/2 start value low/high, 3/4 count low/high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| dbg_halt | input | 1 | Debug halt request |
| timeout | output | 1 | One-cycle end-of-count pulse |

## Verification
The in-RTL properties check these rules on every cycle: the timeout is always a single-cycle pulse, the count never moves while the timer is disabled, frozen or parked after a single-shot end, the reload or park value is right on each timeout, the flag stays set until read, and the load request always clears. Only the directed scenarios can show the exact step spacing for each divider code and the prescaler restart phase. The same holds for the 65536-step behaviour of a zero start value and for the coherence of the split count read, since each of these depends on a count of cycles measured at the ports.

// File: rtl/prt_pkg.sv
package prt_pkg;
   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] RA_RLD_LO = 3'd1;
   localparam logic [ADDR_W-1:0] RA_RLD_HI = 3'd2;
   localparam logic [ADDR_W-1:0] RA_CNT_LO = 3'd3;
   localparam logic [ADDR_W-1:0] RA_CNT_HI = 3'd4;

   localparam int unsigned B_EN   = 0;
   localparam int unsigned B_LD   = 1;
   localparam int unsigned B_DIV  = 2;
   localparam int unsigned B_CONT = 4;
   localparam int unsigned B_FRZ  = 5;
   localparam int unsigned B_FLAG = 7;

   typedef struct packed {
      logic       freeze;
      logic       cont;
      logic [1:0] div;
      logic       load;
      logic       en;
   } ctrl_t;
endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
   parameter int unsigned DIV_BASE_LOG2 = 2,
   parameter int unsigned DIV_STEP_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       advance,
   input  logic [1:0] div_sel,
   output logic       tick
);
   localparam int unsigned PRE_W = DIV_BASE_LOG2 + 3 * DIV_STEP_LOG2;

   if (DIV_BASE_LOG2 < 1 || PRE_W > 30) begin : g_bad_div
      $error("prt_prescaler: divider parameters out of range");
   end

   logic [PRE_W-1:0] lim_tab [4];
   logic [PRE_W-1:0] limit;
   logic [PRE_W-1:0] pre_q;

   for (genvar g = 0; g < 4; g++) begin : g_lim
      assign lim_tab[g] = PRE_W'((1 << (DIV_BASE_LOG2 + DIV_STEP_LOG2 * g)) - 1);
   end

   assign limit = lim_tab[div_sel];
   assign tick  = advance && !restart && (pre_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else if (advance) pre_q <= (pre_q == limit) ? '0 : pre_q + 1'b1;
   end

   AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R4
endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             freeze_req,
   input  logic             load,
   input  logic             cont,
   input  logic [CNT_W-1:0] reload,
   input  logic             tick,
   output logic             advance,
   output logic             restart,
   output logic [CNT_W-1:0] count,
   output logic             timeout
);
   logic en_q, expired_q, last_step;

   assign advance   = enable && !freeze_req && !expired_q;
   assign restart   = load || (enable && !en_q);
   assign last_step = tick && (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         expired_q <= 1'b0;
         count     <= '0;
         timeout   <= 1'b0;
      end else begin
         en_q    <= enable;
         timeout <= last_step && !load;
         if (load) begin
            count     <= reload;
            expired_q <= 1'b0;
         end else if (last_step) begin
            count     <= cont ? reload : '0;
            expired_q <= !cont;
         end else if (tick) begin
            count <= count - 1'b1;
         end
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout); // R7
   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !load) |=> $stable(count)); // R2
   AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !timeout); // R2
   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_req && !load) |=> $stable(count)); // R9
   AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && $past(cont)) |-> (count == $past(reload))); // R6
   AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !$past(cont)) |-> (count == '0)); // R5
   AST_PARKED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_q && !load) |=> $stable(count)); // R5
endmodule

// File: rtl/prt_regs.sv
module prt_regs
   import prt_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          SNAP_HI = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [2*DATA_W-1:0] count,
   input  logic                timeout,
   output ctrl_t               ctl,
   output logic [2*DATA_W-1:0] reload,
   output logic [DATA_W-1:0]   rdata
);
   localparam int unsigned CNT_W = 2 * DATA_W;

   logic en_q, ld_q, cont_q, frz_q, flag_q;
   logic [1:0] div_q;
   logic [DATA_W-1:0] rld_lo_q, rld_hi_q, cnt_hi_rd;
   logic ctl_wr, ctl_rd, lo_rd;

   assign ctl_wr = wr_en && (addr == RA_CTRL);
   assign ctl_rd = rd_en && (addr == RA_CTRL);
   assign lo_rd  = rd_en && (addr == RA_CNT_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; ld_q <= 1'b0; cont_q <= 1'b0; frz_q <= 1'b0;
         div_q <= 2'b00; flag_q <= 1'b0;
         rld_lo_q <= '0; rld_hi_q <= '0;
      end else begin
         ld_q <= ctl_wr && wdata[B_LD];
         if (ctl_wr) begin
            en_q   <= wdata[B_EN];
            div_q  <= wdata[B_DIV +: 2];
            cont_q <= wdata[B_CONT];
            frz_q  <= wdata[B_FRZ];
         end
         if (wr_en && addr == RA_RLD_LO) rld_lo_q <= wdata;
         if (wr_en && addr == RA_RLD_HI) rld_hi_q <= wdata;
         if (timeout)     flag_q <= 1'b1;
         else if (ctl_rd) flag_q <= 1'b0;
      end
   end

   if (SNAP_HI) begin : g_snap
      logic [DATA_W-1:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     hi_q <= '0;
         else if (lo_rd) hi_q <= count[CNT_W-1:DATA_W];
      end
      assign cnt_hi_rd = hi_q;
      AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
         lo_rd |=> (hi_q == $past(count[CNT_W-1:DATA_W]))); // R11
   end else begin : g_live
      assign cnt_hi_rd = count[CNT_W-1:DATA_W];
   end

   assign ctl    = '{freeze: frz_q, cont: cont_q, div: div_q, load: ld_q, en: en_q};
   assign reload = {rld_hi_q, rld_lo_q};

   always_comb begin
      rdata = '0;
      case (addr)
         RA_CTRL:   rdata = DATA_W'({flag_q, 1'b0, frz_q, cont_q, div_q, ld_q, en_q});
         RA_RLD_LO: rdata = rld_lo_q;
         RA_RLD_HI: rdata = rld_hi_q;
         RA_CNT_LO: rdata = count[DATA_W-1:0];
         RA_CNT_HI: rdata = cnt_hi_rd;
         default:   rdata = '0;
      endcase
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> flag_q); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !ctl_rd) |=> flag_q); // R8
   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_q && !ctl_wr) |=> !ld_q); // R3
endmodule

// File: rtl/reload_timer_top.sv
module reload_timer_top
   import prt_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned DIV_BASE_LOG2 = 2,
   parameter int unsigned DIV_STEP_LOG2 = 2,
   parameter bit          SNAP_HI       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              dbg_halt,
   output logic              timeout
);
   localparam int unsigned CNT_W = 2 * DATA_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("reload_timer_top: DATA_W must hold the 8 control bits");
   end

   ctrl_t            ctl;
   logic [CNT_W-1:0] reload, count;
   logic             tick, advance, restart;

   prt_regs #(.DATA_W(DATA_W), .SNAP_HI(SNAP_HI)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .count(count), .timeout(timeout),
      .ctl(ctl), .reload(reload), .rdata(rdata)
   );

   prt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .enable(ctl.en),
      .freeze_req(dbg_halt && ctl.freeze), .load(ctl.load), .cont(ctl.cont),
      .reload(reload), .tick(tick), .advance(advance), .restart(restart),
      .count(count), .timeout(timeout)
   );

   prt_prescaler #(.DIV_BASE_LOG2(DIV_BASE_LOG2), .DIV_STEP_LOG2(DIV_STEP_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
      .div_sel(ctl.div), .tick(tick)
   );
endmodule

// File: tb/sim_reload_timer_top.sv
module sim_reload_timer_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, dbg_halt = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       timeout;

   int nchk = 0, nfail = 0, t = 0, pulses = 0;

   localparam logic [7:0] C_EN = 8'h01, C_LD = 8'h02, C_CONT = 8'h10, C_FRZ = 8'h20;

   always #10 clk = ~clk;

   reload_timer_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .dbg_halt(dbg_halt), .timeout(timeout)
   );

   always @(negedge clk) if (timeout) pulses++;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      t += n;
   endtask

   task automatic go(input int target);
      if (target > t) step(target - t);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; t++;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0; t++;
   endtask

   task automatic rd_cnt(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(3'd3, lo);
      rd(3'd4, hi);
      v = {hi, lo};
   endtask

   task automatic chk_cnt(input int at, input logic [15:0] exp, input string tag);
      logic [15:0] v;
      go(at);
      rd_cnt(v);
      check(v == exp, tag, v, exp);
   endtask

   task automatic chk_to(input int at, input logic exp, input string tag);
      go(at);
      #1 check(timeout == exp, tag, timeout, exp);
   endtask

   task automatic start(input logic [15:0] rv, input logic [7:0] c);
      wr(3'd1, rv[7:0]);
      wr(3'd2, rv[15:8]);
      wr(3'd0, c | C_LD);
      step(1);
      t = 0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      logic [15:0] v;
      rd(3'd0, d); check(d == 8'h00, "R1 ctrl", d, 0);
      rd(3'd1, d); check(d == 8'h00, "R1 rld_lo", d, 0);
      rd(3'd2, d); check(d == 8'h00, "R1 rld_hi", d, 0);
      rd_cnt(v);   check(v == 16'h0, "R1 count", v, 0);
      check(timeout == 1'b0, "R1 timeout", timeout, 0);
   endtask

   task automatic t_disabled();
      logic [7:0] d;
      int p0;
      start(16'd9, 8'h00);
      p0 = pulses;
      rd(3'd0, d); check(d == 8'h00, "R3 load bit cleared", d, 0);
      chk_cnt(1, 16'd9, "R3 loaded while disabled");
      chk_cnt(60, 16'd9, "R2 count held while disabled");
      #1 check(pulses == p0, "R2 no pulse while disabled", pulses - p0, 0);
   endtask

   task automatic t_div();
      for (int d = 0; d < 4; d++) begin
         int n;
         n = 4 << (2 * d);
         start(16'd20, C_EN | 8'(d << 2));
         chk_cnt(n - 1, 16'd20, $sformatf("R4 R12 div code %0d before step", d));
         chk_cnt(2 * n, 16'd18, $sformatf("R4 div code %0d two steps", d));
      end
   endtask

   task automatic t_enable_restart();
      start(16'd100, C_EN | 8'h04);
      chk_cnt(40, 16'd98, "R4 div16 running");
      wr(3'd0, 8'h04);
      chk_cnt(60, 16'd98, "R2 held after disable");
      wr(3'd0, C_EN | 8'h04);
      step(1); t = 0;
      chk_cnt(15, 16'd98, "R12 enable restarts prescaler");
      chk_cnt(32, 16'd96, "R12 steps after enable");
   endtask

   task automatic t_oneshot();
      logic [7:0] d;
      int p0;
      rd(3'd0, d);
      start(16'd2, C_EN);
      p0 = pulses;
      chk_to(7, 1'b0, "R7 no pulse early");
      chk_to(8, 1'b1, "R7 pulse on last tick");
      chk_to(9, 1'b0, "R7 pulse one cycle");
      chk_cnt(40, 16'd0, "R5 parked at zero");
      #1 check(pulses - p0 == 1, "R5 single pulse", pulses - p0, 1);
      rd(3'd0, d); check(d == 8'h81, "R8 flag set on read", d, 8'h81);
      rd(3'd0, d); check(d == 8'h01, "R8 flag cleared by read", d, 8'h01);
   endtask

   task automatic t_continuous();
      logic [15:0] v;
      int p0;
      start(16'd3, C_EN | C_CONT);
      p0 = pulses;
      chk_to(11, 1'b0, "R6 no pulse early");
      chk_to(12, 1'b1, "R6 first pulse");
      rd_cnt(v); check(v == 16'd3, "R6 reloaded on timeout", v, 3);
      chk_to(24, 1'b1, "R6 second pulse");
      chk_to(25, 1'b0, "R7 pulse one cycle");
      go(100);
      #1 check(pulses - p0 == 8, "R6 pulse count", pulses - p0, 8);
      wr(3'd0, 8'h00);
   endtask

   task automatic t_freeze();
      logic [15:0] v;
      start(16'd50, C_EN | C_FRZ);
      dbg_halt = 1'b1;
      chk_cnt(40, 16'd50, "R9 frozen during halt");
      dbg_halt = 1'b0;
      chk_cnt(60, 16'd46, "R9 resumes after halt");
      wr(3'd0, C_EN);
      dbg_halt = 1'b1;
      step(40);
      rd_cnt(v);
      check(v < 16'd41, "R9 runs through halt with freeze clear", v, 40);
      dbg_halt = 1'b0;
   endtask

   task automatic t_wrap();
      int p0;
      start(16'h0000, C_EN);
      p0 = pulses;
      chk_cnt(3, 16'h0000, "R10 zero before first tick");
      chk_cnt(5, 16'hFFFF, "R10 wraps to FFFF");
      #1 check(pulses == p0, "R10 no timeout at wrap", pulses - p0, 0);
   endtask

   task automatic t_snapshot();
      logic [7:0] d;
      start(16'h0201, C_EN);
      rd(3'd3, d); check(d == 8'h01, "R11 low byte", d, 8'h01);
      go(9);
      rd(3'd4, d); check(d == 8'h02, "R11 high byte from snapshot", d, 8'h02);
      rd(3'd3, d); check(d == 8'hFF, "R11 live low byte", d, 8'hFF);
      rd(3'd4, d); check(d == 8'h01, "R11 new snapshot", d, 8'h01);
   endtask

   initial begin
      #(20 * 190000);
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_div();
      t_enable_restart();
      t_oneshot();
      t_continuous();
      t_freeze();
      t_wrap();
      t_snapshot();
      report();
   end
endmodule